// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a timekeeping peripheral that counts whole seconds in a 32-bit register. A one-cycle strobe on `tick_32k` arrives from the slow oscillator domain, already synchronised to `clk`. A prescaler turns every `TICKS_PER_SEC` of these strobes into one step of the seconds counter. A second 32-bit register holds an alarm time. When the alarm is armed and the counter reaches that time, a sticky alarm flag rises. Each step of the counter also raises a sticky one-second flag. The interrupt line is high while either flag is up and its enable bit is set. A spare 32-bit scratch register keeps a value that software can test.

Software reaches the registers through a request channel and a read-response channel, both valid/ready. A request moves when `req_valid` and `req_ready` are both high at a rising edge. Each read returns exactly one response, and responses come back in request order. A response stays on `rsp_rdata`, unchanged, until `rsp_ready` takes it. While a response is waiting and `rsp_ready` is low, `req_ready` is low. This is the only back-pressure in the block, so one read can be outstanding at a time. Writes produce no response.

Register writes are guarded twice. First, a key must be written to arm writing. Second, the write-ready bit must be high. An accepted write uses up the key. It also holds write-ready low for `BUSY_CYC` cycles, which models the transfer into the slow domain.

Top module: `sec_rtc`

## Requirements
- R1: After reset every register reads 0, except the control register, which reads 0x00000080 because write-ready (bit 7) is 1. The key register reads 0 and `irq` is 0.
- R2: Writing 0x0000A55A to the key register (byte offset 0x3C) arms writing, and that register then reads 0x80000000 (bit 31 set). Writing any other value to it disarms writing.
- R3: A write to the control (0x00), seconds (0x04), alarm (0x08) or scratch (0x34) register while writing is not armed changes nothing.
- R4: A write to one of those four registers is accepted only while it is armed and write-ready is 1. An accepted write disarms the key and holds write-ready low for `BUSY_CYC` cycles. A write attempted while write-ready is 0 is ignored and leaves the key armed.
- R5: While the count-enable bit (control bit 0) is 1, the seconds counter rises by one for every `TICKS_PER_SEC` tick strobes and wraps from 0xFFFFFFFF to 0. While the bit is 0 the counter holds. A write sets the counter to any 32-bit value.
- R6: Every step of the seconds counter sets the one-second flag (control bit 6), and the flag stays set until it is cleared.
- R7: While the alarm is armed (control bit 2), the alarm flag (bit 4) is set in every cycle in which the seconds counter equals the alarm register. Clearing the flag while the match persists has no effect. While the alarm is not armed, the flag is never set.
- R8: A control write loads the enable bits 0, 2, 3 and 5 from the written data. For the flag bits 4 and 6, writing 0 clears the flag and writing 1 leaves it unchanged. If a flag's set event falls in the same cycle as a clear, the flag ends up set.
- R9: `irq` equals (bit 6 AND bit 5) OR (bit 4 AND bit 3) of the control register.
- R10: A read of the control register returns bit 7 write-ready, bit 6 one-second flag, bit 5 one-second interrupt enable, bit 4 alarm flag, bit 3 alarm interrupt enable, bit 2 alarm arm, bit 0 count enable, and all other bits 0. A read of an unmapped offset returns 0.
- R11: The scratch register stores and returns a full 32-bit value. A pending read response is held stable, with `req_ready` low, until `rsp_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per slow-oscillator period |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 4 and `BUSY_CYC` = 4. With these values a counter step takes only a few dozen cycles, so the bench can reach stepping, wrapping at 0xFFFFFFFF and alarm matching within a short run. A 4-cycle busy window is short enough that a key write followed by a register write can land inside it, which shows that such a write is ignored and leaves the key armed. Holding `rsp_ready` low exercises the back-pressure path.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SECS  = 8'h04;
  localparam logic [7:0] OFF_ALARM = 8'h08;
  localparam logic [7:0] OFF_SCR   = 8'h34;
  localparam logic [7:0] OFF_KEY   = 8'h3C;

  localparam logic [DW-1:0] UNLOCK_WORD = 32'h0000_A55A;

  localparam int B_CNT_EN = 0;
  localparam int B_ALM_EN = 2;
  localparam int B_ALM_IE = 3;
  localparam int B_ALM_F  = 4;
  localparam int B_SEC_IE = 5;
  localparam int B_SEC_F  = 6;
  localparam int B_WRDY   = 7;
  localparam int B_ARMED  = 31;

  typedef struct packed {
    logic sec_f;
    logic sec_ie;
    logic alm_f;
    logic alm_ie;
    logic alm_en;
    logic cnt_en;
  } ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_in,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      if (!run) begin
        cnt_q <= '0;
      end else if (tick_in) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          sec_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sec_pulse) else $error("pulse while stopped"); // R5
endmodule

// File: rtl/rtc_write_gate.sv
`timescale 1ns/1ps
module rtc_write_gate
  import rtc_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_wdata,
  input  logic          reg_we,
  output logic          wr_ok,
  output logic          wrdy,
  output logic          armed
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYC);

  logic [BW-1:0] busy_q;

  assign wrdy  = (busy_q == '0);
  assign wr_ok = reg_we && armed && wrdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      armed  <= 1'b0;
    end else begin
      if (wr_ok)
        busy_q <= BUSY_LOAD;
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;

      if (wr_ok)
        armed <= 1'b0;
      else if (key_we)
        armed <= (key_wdata == UNLOCK_WORD);
    end
  end

  AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !wrdy) else $error("write-ready stayed high"); // R4
  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !armed) else $error("key survived a write"); // R4
  AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_wdata == UNLOCK_WORD) |=> armed) else $error("key not armed"); // R2
  AST_BLOCKED_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && armed && !wrdy) |=> armed) else $error("blocked write used key"); // R4
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_pulse,
  input  logic          ctrl_we,
  input  logic          secs_we,
  input  logic          alarm_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] secs_q,
  output logic [DW-1:0] alarm_q,
  output ctrl_t         ctrl_q,
  output logic          irq
);
  logic step;
  logic alarm_hit;
  logic sec_f_kept;
  logic alm_f_kept;

  assign step      = sec_pulse && ctrl_q.cnt_en && !secs_we;
  assign alarm_hit = ctrl_q.alm_en && (secs_q == alarm_q);
  assign sec_f_kept = ctrl_we ? (ctrl_q.sec_f & wdata[B_SEC_F]) : ctrl_q.sec_f;
  assign alm_f_kept = ctrl_we ? (ctrl_q.alm_f & wdata[B_ALM_F]) : ctrl_q.alm_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      alarm_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (secs_we)
        secs_q <= wdata;
      else if (step)
        secs_q <= secs_q + 1'b1;

      if (alarm_we)
        alarm_q <= wdata;

      ctrl_q.sec_f <= sec_f_kept | step;
      ctrl_q.alm_f <= alm_f_kept | alarm_hit;
      if (ctrl_we) begin
        ctrl_q.cnt_en <= wdata[B_CNT_EN];
        ctrl_q.alm_en <= wdata[B_ALM_EN];
        ctrl_q.alm_ie <= wdata[B_ALM_IE];
        ctrl_q.sec_ie <= wdata[B_SEC_IE];
      end
    end
  end

  assign irq = (ctrl_q.sec_f && ctrl_q.sec_ie) || (ctrl_q.alm_f && ctrl_q.alm_ie);

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && ctrl_q.cnt_en && !secs_we) |=> secs_q == $past(secs_q) + 1'b1)
    else $error("counter missed a step"); // R5
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !secs_we) |=> $stable(secs_q)) else $error("counter drifted"); // R5
  AST_ALARM_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.alm_en && secs_q == alarm_q) |=> ctrl_q.alm_f) else $error("alarm missed"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sec_f && !ctrl_we) |=> ctrl_q.sec_f) else $error("flag dropped"); // R6
endmodule

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TICKS_PER_SEC = 32768,
  parameter int BUSY_CYC      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq
);
  logic req_fire, wr_fire, rd_fire;
  logic hit_ctrl, hit_secs, hit_alarm, hit_scr, hit_key;
  logic key_we, reg_we, wr_ok, wrdy, armed;
  logic sec_pulse;
  logic [DW-1:0] secs_q, alarm_q, scr_q, rd_mux;
  ctrl_t ctrl_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;
  assign rd_fire   = req_fire && !req_write;

  assign hit_ctrl  = (req_addr == ADDR_W'(OFF_CTRL));
  assign hit_secs  = (req_addr == ADDR_W'(OFF_SECS));
  assign hit_alarm = (req_addr == ADDR_W'(OFF_ALARM));
  assign hit_scr   = (req_addr == ADDR_W'(OFF_SCR));
  assign hit_key   = (req_addr == ADDR_W'(OFF_KEY));

  assign key_we = wr_fire && hit_key;
  assign reg_we = wr_fire && (hit_ctrl || hit_secs || hit_alarm || hit_scr);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.cnt_en),
    .tick_in   (tick_32k),
    .sec_pulse (sec_pulse)
  );

  rtc_write_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_we    (key_we),
    .key_wdata (req_wdata),
    .reg_we    (reg_we),
    .wr_ok     (wr_ok),
    .wrdy      (wrdy),
    .armed     (armed)
  );

  rtc_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .ctrl_we   (wr_ok && hit_ctrl),
    .secs_we   (wr_ok && hit_secs),
    .alarm_we  (wr_ok && hit_alarm),
    .wdata     (req_wdata),
    .secs_q    (secs_q),
    .alarm_q   (alarm_q),
    .ctrl_q    (ctrl_q),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scr_q <= '0;
    else if (wr_ok && hit_scr)
      scr_q <= req_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[B_WRDY]   = wrdy;
      rd_mux[B_SEC_F]  = ctrl_q.sec_f;
      rd_mux[B_SEC_IE] = ctrl_q.sec_ie;
      rd_mux[B_ALM_F]  = ctrl_q.alm_f;
      rd_mux[B_ALM_IE] = ctrl_q.alm_ie;
      rd_mux[B_ALM_EN] = ctrl_q.alm_en;
      rd_mux[B_CNT_EN] = ctrl_q.cnt_en;
    end else if (hit_secs) begin
      rd_mux = secs_q;
    end else if (hit_alarm) begin
      rd_mux = alarm_q;
    end else if (hit_scr) begin
      rd_mux = scr_q;
    end else if (hit_key) begin
      rd_mux[B_ARMED] = armed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
    else $error("response changed while stalled"); // R11
  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready) else $error("request taken while stalled"); // R11
endmodule

// File: tb/sec_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_tb_top;
  localparam int TPS  = 4;
  localparam int BUSY = 4;
  localparam logic [31:0] KEY = 32'h0000_A55A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sec_rtc #(.ADDR_W(8), .TICKS_PER_SEC(TPS), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all driver tasks start and end just after a falling edge
  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, 32'h0);
  endtask

  task automatic pw(input logic [7:0] a, input logic [31:0] d);
    wr(8'h3C, KEY);
    wr(a, d);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1'b1; @(negedge clk);
      tick_32k = 1'b0; @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
        end else begin
          chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, 32'h80, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 secs");
    rd(8'h08, 32'h0, "R1 alarm");
    rd(8'h34, 32'h0, "R1 scratch");
    rd(8'h3C, 32'h0, "R1 key");

    // R3 write without key ignored
    wr(8'h04, 32'h55);
    rd(8'h04, 32'h0, "R3 secs unchanged");

    // R2 arm and disarm
    wr(8'h3C, KEY);
    rd(8'h3C, 32'h8000_0000, "R2 armed");
    wr(8'h3C, 32'h1234);
    rd(8'h3C, 32'h0, "R2 disarmed");

    // R11 scratch full width
    pw(8'h34, 32'hDEAD_BEEF);
    rd(8'h34, 32'hDEAD_BEEF, "R11 scratch");
    repeat (2) @(negedge clk);

    // R4 busy window and key spending
    wr(8'h3C, KEY);
    wr(8'h34, 32'h1);
    rd(8'h00, 32'h00, "R4 write-ready low");
    rd(8'h3C, 32'h0, "R4 key spent");
    wr(8'h3C, KEY);
    wr(8'h34, 32'h2);
    rd(8'h34, 32'h1, "R4 busy write ignored");
    rd(8'h3C, 32'h8000_0000, "R4 key kept");
    wr(8'h3C, 32'h0);
    repeat (BUSY) @(negedge clk);
    rd(8'h00, 32'h80, "R4 write-ready back");

    // R5 R6 R8 R9 counting and one-second flag
    pw(8'h04, 32'd10);
    pw(8'h00, 32'h21);
    ticks(3 * TPS);
    rd(8'h00, 32'hE1, "R6 flag set");
    chk("R9 irq sec", {31'b0, irq}, 32'h1);
    pw(8'h00, 32'h40);
    rd(8'h00, 32'hC0, "R8 write 1 keeps flag");
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h04, 32'd13, "R5 three steps");
    ticks(2 * TPS);
    rd(8'h04, 32'd13, "R5 frozen");
    pw(8'h00, 32'h00);
    rd(8'h00, 32'h80, "R8 write 0 clears flag");

    // R5 wrap
    pw(8'h04, 32'hFFFF_FFFF);
    pw(8'h00, 32'h01);
    ticks(TPS);
    rd(8'h04, 32'h0, "R5 wrap");
    pw(8'h00, 32'h00);

    // R7 alarm
    pw(8'h08, 32'h20);
    pw(8'h04, 32'h1F);
    pw(8'h00, 32'h0D);
    rd(8'h00, 32'h8D, "R10 ctrl layout");
    ticks(TPS);
    rd(8'h00, 32'hDD, "R7 alarm flag");
    chk("R9 irq alarm", {31'b0, irq}, 32'h1);
    pw(8'h00, 32'h4C);
    rd(8'h00, 32'hDC, "R7 match persists");
    pw(8'h00, 32'h58);
    pw(8'h00, 32'h48);
    rd(8'h00, 32'hC8, "R7 disarmed no flag");
    chk("R9 irq none", {31'b0, irq}, 32'h0);
    pw(8'h00, 32'h60);
    chk("R9 irq sec again", {31'b0, irq}, 32'h1);
    pw(8'h00, 32'h00);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    rd(8'h08, 32'h20, "R7 alarm reg");

    // R10 unmapped, R11 back-pressure
    rd(8'h10, 32'h0, "R10 unmapped");
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    rd(8'h34, 32'h1, "R11 held response");
    repeat (3) @(negedge clk);
    chk("R11 req_ready low", {31'b0, req_ready}, 32'h0);
    chk("R11 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule